// File: doc/BRIEF.md
# Three-Channel Match-Compare Timer

This peripheral holds three independent 32-bit up-counters. Every counter is compared against three programmable match values. Each match comparison has a sticky status bit and an enable bit, and every timer drives one interrupt line. All counters advance on a shared tick-enable strobe. Each timer either runs free, wrapping past all-ones, or reloads to zero on the tick where it equals its first match value.

Software reaches the block through a flat word-addressed register port: an address, a write strobe with write data, and a combinational read-data bus. Address 0x00 holds one run bit per timer. Timer t (t = 0..2) owns the addresses whose upper nibble is t+1. Within that window, the lower nibble selects one of eight registers. A live count is never read directly. Software first writes the timer's snapshot register and then reads the frozen copy.

Top module: `tmr_match_unit`

## Requirements
- R1: After reset every register reads zero: run bits, match values, status, enables, mode and snapshot. All interrupt outputs are low.
- R2: Bit t of the run register at address 0x00 (bits 2:0, readback zero-extended) starts timer t. A timer whose bit is clear does not count.
- R3: A running timer in free-running mode adds one on each cycle with tick_en high, wrapping from all-ones to zero. It holds its value on cycles with tick_en low.
- R4: With the mode register (lower offset 6, bit 0) set to 1, a tick that finds the count equal to match 0 loads zero, so the period is match0+1 ticks.
- R5: Status bit k (lower offset 3, bits 2:0) is set by a tick that finds the count equal to match k (lower offsets 0, 1, 2). A match value of N-1 therefore flags after N ticks from zero. The bit stays set until it is cleared.
- R6: Writing the clear register (lower offset 5) clears each status bit whose data bit is 1. Other status bits are unaffected, 0x7 clears all three, and the clear register reads as zero.
- R7: When a clear write and a new match of the same bit fall on the same cycle, the status bit remains set.
- R8: irq[t] is high exactly while some status bit of timer t and the same bit of its enable register (lower offset 4, bits 2:0) are both 1. An enable value of 0 holds irq[t] low.
- R9: A write to the snapshot register (lower offset 7) stores the live count. Reads of that register return the stored value until the next snapshot write.
- R10: Clearing a timer's run bit returns its count to zero one cycle later, so re-enabling it starts counting from zero.
- R11: Match registers read back all 32 written bits. The enable register reads back only bits 2:0, and the mode register only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| tick_en | input | 1 | Count strobe shared by all timers |
| bus_addr | input | 8 | Word address: upper nibble 0 for the run register, t+1 for timer t; lower nibble selects the register |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Interrupt per timer |

## Verification
A counter that steps wrongly, reloads at the wrong value or survives a stop shows up as a wrong snapshot on the first snapshot write after the fault. It also shifts the tick on which a match status appears, so the status read or irq line is wrong within the same or the next cycle. A status bit that drops early, ignores its clear mask or loses against a simultaneous clear reads wrong on the very next status read. A broken enable mask is visible at once on irq.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int TMR_NT = 3;   // timers
  localparam int TMR_NM = 3;   // match comparators per timer
  localparam int TMR_CW = 32;  // counter and data width
  localparam int TMR_AW = 8;   // word address width

  // lower-nibble register selector inside a timer window
  typedef enum logic [3:0] {
    OFF_M0   = 4'h0,
    OFF_M1   = 4'h1,
    OFF_M2   = 4'h2,
    OFF_STAT = 4'h3,
    OFF_IEN  = 4'h4,
    OFF_CLR  = 4'h5,
    OFF_MODE = 4'h6,
    OFF_SNAP = 4'h7
  } tmr_off_e;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          periodic,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap_hit;

  assign wrap_hit = periodic && (cnt_q == top_val);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (wrap_hit) cnt_d = '0;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_match_slot.sv
`timescale 1ns/1ps
module tmr_match_slot #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] match_val,
  input  logic          clr,
  output logic          stat_o
);
  logic stat_q, stat_d, hit;

  assign hit = step && (cnt == match_val);

  // a fresh hit takes priority over a clear in the same cycle
  always_comb begin
    stat_d = (stat_q && !clr) || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = TMR_CW,
  parameter int NM = TMR_NM
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic                   run,
  input  logic                   wr_en,
  input  logic [3:0]             sel,
  input  logic [CW-1:0]          wdata,
  output logic [CW-1:0]          cnt_o,
  output logic [NM-1:0][CW-1:0]  match_o,
  output logic [NM-1:0]          stat_o,
  output logic [NM-1:0]          ien_o,
  output logic                   mode_o
);
  logic [NM-1:0][CW-1:0] match_q;
  logic [NM-1:0]         ien_q, ien_d, clr_vec;
  logic                  mode_q, mode_d, ien_en, mode_en;
  logic                  step;

  assign step    = run && tick_en;
  assign ien_en  = wr_en && (sel == OFF_IEN);
  assign mode_en = wr_en && (sel == OFF_MODE);
  assign ien_d   = wdata[NM-1:0];
  assign mode_d  = wdata[0];
  assign clr_vec = (wr_en && (sel == OFF_CLR)) ? wdata[NM-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_d;
  end

  for (genvar k = 0; k < NM; k++) begin : g_slot
    logic m_en;
    assign m_en = wr_en && (sel == 4'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    match_q[k] <= '0;
      else if (m_en) match_q[k] <= wdata;
    end

    tmr_match_slot #(.CW(CW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .cnt       (cnt_o),
      .match_val (match_q[k]),
      .clr       (clr_vec[k]),
      .stat_o    (stat_o[k])
    );
  end

  tmr_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick_en),
    .periodic (mode_q),
    .top_val  (match_q[0]),
    .cnt_o    (cnt_o)
  );

  assign match_o = match_q;
  assign ien_o   = ien_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/tmr_match_unit.sv
`timescale 1ns/1ps
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int NT = TMR_NT,
  parameter int NM = TMR_NM,
  parameter int CW = TMR_CW,
  parameter int AW = TMR_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NT-1:0] irq
);
  localparam int HW = AW - 4;

  logic [1:0]                     rst_sync;
  logic                           rst_sn;
  logic [HW-1:0]                  a_hi;
  logic [3:0]                     a_lo;
  logic [NT-1:0]                  run_q, run_d;
  logic                           run_en;
  logic [NT-1:0]                  ch_wr;
  logic [NT-1:0][CW-1:0]          cnt, snap_q;
  logic [NT-1:0][NM-1:0][CW-1:0]  mtch;
  logic [NT-1:0][NM-1:0]          stat, ien;
  logic [NT-1:0]                  mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  assign a_hi   = bus_addr[AW-1:4];
  assign a_lo   = bus_addr[3:0];
  assign run_en = bus_wr && (a_hi == '0) && (a_lo == 4'h0);
  assign run_d  = bus_wdata[NT-1:0];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic snap_en;
    assign ch_wr[t] = bus_wr && (a_hi == HW'(t + 1));
    assign snap_en  = ch_wr[t] && (a_lo == OFF_SNAP);

    tmr_channel #(.CW(CW), .NM(NM)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sn),
      .tick_en (tick_en),
      .run     (run_q[t]),
      .wr_en   (ch_wr[t]),
      .sel     (a_lo),
      .wdata   (bus_wdata),
      .cnt_o   (cnt[t]),
      .match_o (mtch[t]),
      .stat_o  (stat[t]),
      .ien_o   (ien[t]),
      .mode_o  (mode[t])
    );

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)      snap_q[t] <= '0;
      else if (snap_en) snap_q[t] <= cnt[t];
    end

    assign irq[t] = |(stat[t] & ien[t]);
  end

  always_comb begin
    bus_rdata = '0;
    if (a_hi == '0) begin
      if (a_lo == 4'h0) bus_rdata = CW'(run_q);
    end
    for (int t = 0; t < NT; t++) begin
      if (a_hi == HW'(t + 1)) begin
        for (int k = 0; k < NM; k++) begin
          if (a_lo == 4'(k)) bus_rdata = mtch[t][k];
        end
        case (a_lo)
          OFF_STAT: bus_rdata = CW'(stat[t]);
          OFF_IEN:  bus_rdata = CW'(ien[t]);
          OFF_MODE: bus_rdata = CW'(mode[t]);
          OFF_SNAP: bus_rdata = snap_q[t];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_match_unit_chk.sv
`timescale 1ns/1ps
module tmr_match_unit_chk #(
  parameter int NT = 3,
  parameter int NM = 3,
  parameter int CW = 32,
  parameter int AW = 8
) (
  input logic                          clk,
  input logic                          rst_sn,
  input logic                          tick_en,
  input logic                          bus_wr,
  input logic [AW-1:0]                 bus_addr,
  input logic [NM-1:0]                 clr_bits,
  input logic [NT-1:0]                 run,
  input logic [NT-1:0]                 mode,
  input logic [NT-1:0][NM-1:0][CW-1:0] mtch,
  input logic [NT-1:0][CW-1:0]         cnt,
  input logic [NT-1:0][NM-1:0]         stat,
  input logic [NT-1:0][NM-1:0]         ien,
  input logic [NT-1:0]                 irq
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    logic clr_hit;
    assign clr_hit = bus_wr && (bus_addr == AW'(((t + 1) << 4) | 5));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      (run[t] && tick_en && !(mode[t] && cnt[t] == mtch[t][0]))
      |=> cnt[t] == $past(cnt[t]) + 1'b1);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      (run[t] && !tick_en) |=> $stable(cnt[t]));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      (run[t] && tick_en && mode[t] && cnt[t] == mtch[t][0]) |=> cnt[t] == '0);

    // R10
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      !run[t] |=> cnt[t] == '0);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      (ien[t] == '0) |-> !irq[t]);

    for (genvar k = 0; k < NM; k++) begin : g_k
      // R5
      hit_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
        (run[t] && tick_en && cnt[t] == mtch[t][k]) |=> stat[t][k]);

      // R5
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
        (stat[t][k] && !(clr_hit && clr_bits[k])) |=> stat[t][k]);
    end
  end
endmodule

bind tmr_match_unit tmr_match_unit_chk #(.NT(NT), .NM(NM), .CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .tick_en  (tick_en),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .clr_bits (bus_wdata[NM-1:0]),
  .run      (run_q),
  .mode     (mode),
  .mtch     (mtch),
  .cnt      (cnt),
  .stat     (stat),
  .ien      (ien),
  .irq      (irq)
);

// File: tb/tmr_match_unit_test.sv
`timescale 1ns/1ps
module tmr_match_unit_test;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  tmr_match_unit uut (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {write?, addr, data, expected read, requirement number}
  localparam int NV = 19;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,        32'h0,        4'd1},  // R1 run bits
    {1'b0, 8'h10, 32'h0,        32'h0,        4'd1},  // R1 match
    {1'b0, 8'h23, 32'h0,        32'h0,        4'd1},  // R1 status
    {1'b0, 8'h34, 32'h0,        32'h0,        4'd1},  // R1 enable
    {1'b0, 8'h36, 32'h0,        32'h0,        4'd1},  // R1 mode
    {1'b0, 8'h37, 32'h0,        32'h0,        4'd1},  // R1 snapshot
    {1'b1, 8'h10, 32'h12345678, 32'h0,        4'd11},
    {1'b0, 8'h10, 32'h0,        32'h12345678, 4'd11}, // R11 full width
    {1'b1, 8'h24, 32'hffffffff, 32'h0,        4'd11},
    {1'b0, 8'h24, 32'h0,        32'h7,        4'd11}, // R11 three bits
    {1'b1, 8'h36, 32'h3,        32'h0,        4'd11},
    {1'b0, 8'h36, 32'h0,        32'h1,        4'd11}, // R11 one bit
    {1'b0, 8'h25, 32'h0,        32'h0,        4'd6},  // R6 clear reads zero
    {1'b1, 8'h00, 32'hff,       32'h0,        4'd2},
    {1'b0, 8'h00, 32'h0,        32'h7,        4'd2},  // R2 run readback
    {1'b1, 8'h00, 32'h0,        32'h0,        4'd2},
    {1'b1, 8'h10, 32'h0,        32'h0,        4'd11},
    {1'b1, 8'h24, 32'h0,        32'h0,        4'd11},
    {1'b1, 8'h36, 32'h0,        32'h0,        4'd11}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock edge with the given bus and tick values
  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t;
    @(posedge clk);
    #1 bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic [2:0] exp);
    @(negedge clk);
    #1 check(tag, {29'b0, irq}, {29'b0, exp});
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();
    irq_chk("R1 irq after reset", 3'b000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:68], VEC[i][67:36]);
      else begin
        @(negedge clk);
        bus_addr = VEC[i][75:68];
        #1 check($sformatf("R%0d vector %0d", VEC[i][3:0], i), bus_rdata, VEC[i][35:4]);
      end
    end

    // timer 0: match after N ticks, snapshot, sticky status, clear
    wr(8'h10, 32'd4); wr(8'h11, 32'd100); wr(8'h12, 32'd200);
    wr(8'h14, 32'h1); wr(8'h00, 32'h1);
    ticks(4);
    rd_chk("R5 no match before N ticks", 8'h13, 32'h0);
    ticks(1);
    rd_chk("R5 match on tick N", 8'h13, 32'h1);
    irq_chk("R8 enabled match drives irq", 3'b001);
    wr(8'h27, 32'h0);
    rd_chk("R2 stopped timer stays zero", 8'h27, 32'h0);
    wr(8'h17, 32'h0);
    rd_chk("R9 snapshot value", 8'h17, 32'd5);
    ticks(3);
    rd_chk("R9 snapshot frozen", 8'h17, 32'd5);
    wr(8'h17, 32'h0);
    rd_chk("R9 new snapshot", 8'h17, 32'd8);
    rd_chk("R5 status sticky", 8'h13, 32'h1);
    wr(8'h15, 32'h2);
    rd_chk("R6 other bit untouched", 8'h13, 32'h1);
    wr(8'h15, 32'h7);
    rd_chk("R6 clear all", 8'h13, 32'h0);
    irq_chk("R8 irq low after clear", 3'b000);

    // masking
    wr(8'h11, 32'd10);
    ticks(3);
    rd_chk("R5 match 1 flag", 8'h13, 32'h2);
    irq_chk("R8 masked match", 3'b000);
    wr(8'h14, 32'h2);
    irq_chk("R8 unmasked match", 3'b001);
    wr(8'h14, 32'h0);
    irq_chk("R8 enable zero masks", 3'b000);

    // stop and restart
    wr(8'h00, 32'h0);
    repeat (2) @(posedge clk);
    wr(8'h17, 32'h0);
    rd_chk("R10 stopped count zero", 8'h17, 32'h0);
    wr(8'h00, 32'h1);
    ticks(2);
    wr(8'h17, 32'h0);
    rd_chk("R10 restart from zero", 8'h17, 32'd2);

    // timer 2 periodic
    wr(8'h30, 32'd2); wr(8'h31, 32'd100); wr(8'h32, 32'd100);
    wr(8'h36, 32'h1); wr(8'h34, 32'h1); wr(8'h00, 32'h4);
    ticks(3);
    wr(8'h37, 32'h0);
    rd_chk("R4 reload to zero", 8'h37, 32'h0);
    rd_chk("R4 reload flags match 0", 8'h33, 32'h1);
    irq_chk("R8 timer 2 irq", 3'b100);
    ticks(4);
    wr(8'h37, 32'h0);
    rd_chk("R4 period match0+1", 8'h37, 32'd1);

    // timer 1 free-running, tick gating, hit-vs-clear
    wr(8'h21, 32'd100); wr(8'h22, 32'd9); wr(8'h00, 32'h2);
    repeat (5) @(posedge clk);
    wr(8'h27, 32'h0);
    rd_chk("R3 no count without tick", 8'h27, 32'h0);
    ticks(9);
    wr(8'h27, 32'h0);
    rd_chk("R3 count per tick", 8'h27, 32'd9);
    rd_chk("R5 match 0 at zero", 8'h23, 32'h1);
    drive(1'b1, 8'h25, 32'h4, 1'b1);
    rd_chk("R7 hit wins over clear", 8'h23, 32'h5);
    wr(8'h25, 32'h4);
    rd_chk("R6 single bit clear", 8'h23, 32'h1);

    // reset in the middle of activity
    do_reset();
    rd_chk("R1 run after reset", 8'h00, 32'h0);
    rd_chk("R1 mode after reset", 8'h36, 32'h0);
    rd_chk("R1 match after reset", 8'h22, 32'h0);
    irq_chk("R1 irq after second reset", 3'b000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule